// File: doc/BRIEF.md
# Iterative AES-128 Block Encryptor

This block enciphers a single 128-bit data block with a 128-bit secret key, following the Advanced Encryption Standard. It keeps one round of datapath and runs it once per clock cycle. The round key for each round is derived on the fly from the previous one, in the same cycle as the data round, so the design never stores an expanded key schedule.

A host drives the key and the plaintext and pulses `start_i`. The core first whitens the block with the raw key. It then runs nine full rounds followed by one final round. The final round leaves out column mixing. When the last round is done, the core raises `done_o` and holds the ciphertext on `ctext_o` until the next accepted start.

The byte substitution table is not stored anywhere. Each entry is computed in logic as a field inverse followed by an affine map.

Top module: `aes128_iter_core`

## Requirements
- R1: While `rst` is high, and after it is released, `busy_o` and `done_o` are both low.
- R2: A `start_i` sampled high while the core is not busy latches `key_i` and `ptext_i`. From the next cycle, `busy_o` is high and `done_o` is low. This also holds when `done_o` was high.
- R3: `done_o` rises, and `busy_o` falls, exactly 10 clock edges after the edge that accepted `start_i`. That is the 11th edge when the accepting edge is counted as the first.
- R4: `ctext_o` equals the AES-128 encryption of the latched plaintext under the latched key. Key 000102030405060708090a0b0c0d0e0f with plaintext 00112233445566778899aabbccddeeff gives 69c4e0d86a7b0430d8cdb78070b4c55a.
- R5: Byte substitution first takes the multiplicative inverse of the byte in GF(2^8), reduced by x^8+x^4+x^3+x+1. The byte 00 maps to 00 at this step. The result is then XORed with its rotations left by 1, 2, 3 and 4 bits, and with the constant 63.
- R6: Bytes on the 128-bit buses are in stream order, and byte 0 is bits 127:120. Stream byte k sits at row k mod 4 and column k div 4. Each round turns row r left by r byte positions.
- R7: Rounds 1 to 9 multiply every column by 03·x^3+01·x^2+01·x+02 modulo x^4+1. Round 10 skips this step and applies only substitution, row turning and key addition.
- R8: Each new round key is built from the previous one. Its last word is rotated up by one byte, then substituted, then the top byte is XORed with the step constant. The step constants are 01, 02, 04, 08, 10, 20, 40, 80, 1B and 36. The result is folded through the four words with XOR.
- R9: A `start_i` pulse that arrives while `busy_o` is high is ignored. The running block finishes with its own result and on its original schedule.
- R10: Once high, `done_o` stays high and `ctext_o` stays unchanged until a new `start_i` is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start request, sampled on the rising edge |
| key_i | input | 128 | Cipher key, stream byte 0 in bits 127:120 |
| ptext_i | input | 128 | Plaintext block, stream byte 0 in bits 127:120 |
| busy_o | output | 1 | High while rounds are in progress |
| done_o | output | 1 | High when `ctext_o` holds a finished result |
| ctext_o | output | 128 | Ciphertext, valid while `done_o` is high |

## Verification
The published answer vectors, including the all-zero key and block, catch a reversed byte order, a row turned the wrong way, and a wrong step constant. Any of these would produce a ciphertext that is completely wrong. Random keys and blocks are checked against a bench model whose substitution table is built by brute-force inverse search. This would expose an S-box error that only affects bytes the fixed vectors never touch, and a final round that still mixes columns. A second start in the middle of a run would corrupt or delay the first result if it were not ignored. A wrongly latched done would drop early, or let the ciphertext drift while done is high. A restart issued from the done state must clear done on the very next edge.

// File: rtl/aes_core_pkg.sv
package aes_core_pkg;

    localparam int BYTE_W     = 8;
    localparam int NUM_ROWS   = 4;
    localparam int NUM_COLS   = 4;
    localparam int BLK_BYTES  = NUM_ROWS * NUM_COLS;
    localparam int BLK_W      = BLK_BYTES * BYTE_W;
    localparam int NUM_ROUNDS = 10;
    localparam int RND_W      = $clog2(NUM_ROUNDS + 1);

    localparam logic [BYTE_W-1:0] FIELD_REDUCE = 8'h1B;
    localparam logic [BYTE_W-1:0] AFFINE_CONST = 8'h63;
    localparam logic [BYTE_W-1:0] STEP_SEED    = 8'h01;

    typedef logic [BYTE_W-1:0]         byte_t;
    typedef byte_t [BLK_BYTES-1:0]     state_t;
    typedef byte_t [NUM_ROWS-1:0]      word_t;

    typedef enum logic [1:0] {
        CTL_IDLE,
        CTL_RUN,
        CTL_DONE
    } ctl_e;

    // stream byte (col*4 + row) lives at packed slot 15 - that index,
    // so stream byte 0 is the most significant byte of the bus
    function automatic int slot(input int col, input int row);
        return BLK_BYTES - 1 - (col * NUM_ROWS + row);
    endfunction

    function automatic byte_t xtime(input byte_t a);
        return {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? FIELD_REDUCE : '0);
    endfunction

    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc;
        byte_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = xtime(sh);
        end
        return acc;
    endfunction

    // a^254 by a square-and-multiply chain; 0 maps to 0
    function automatic byte_t gf_inv(input byte_t a);
        byte_t p;
        p = gf_mul(a, a);          // a^2
        p = gf_mul(p, a);          // a^3
        p = gf_mul(p, p);          // a^6
        p = gf_mul(p, a);          // a^7
        p = gf_mul(p, p);          // a^14
        p = gf_mul(p, a);          // a^15
        p = gf_mul(p, p);          // a^30
        p = gf_mul(p, a);          // a^31
        p = gf_mul(p, p);          // a^62
        p = gf_mul(p, a);          // a^63
        p = gf_mul(p, p);          // a^126
        p = gf_mul(p, a);          // a^127
        p = gf_mul(p, p);          // a^254
        return p;
    endfunction

    function automatic byte_t rotl8(input byte_t a, input int n);
        return byte_t'((a << n) | (a >> (BYTE_W - n)));
    endfunction

    function automatic byte_t sub_byte(input byte_t a);
        byte_t v;
        v = gf_inv(a);
        return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ AFFINE_CONST;
    endfunction

    // one output byte of column mixing: 2*a ^ 3*b ^ c ^ d
    function automatic byte_t mix_byte(input byte_t a, input byte_t b,
                                       input byte_t c, input byte_t d);
        return xtime(a) ^ xtime(b) ^ b ^ c ^ d;
    endfunction

endpackage

// File: rtl/aes_sbox.sv
module aes_sbox
    import aes_core_pkg::*;
(
    input  byte_t in_i,
    output byte_t out_o
);

    assign out_o = sub_byte(in_i);

    always_comb begin
        // R5: the substitution has no fixed points and no opposite fixed points
        a_sbox_no_fixed_r5: assert ($isunknown(in_i) || (out_o != in_i && out_o != ~in_i))
            else $error("sbox fixed point");
    end

endmodule

// File: rtl/aes_key_step.sv
module aes_key_step
    import aes_core_pkg::*;
(
    input  state_t rk_i,
    input  byte_t  step_const_i,
    output state_t rk_o
);

    word_t rot_w;
    word_t sub_w;
    word_t mix_w;

    // R8: last word rotated up one byte, then substituted
    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_rot
        localparam int SRC = slot(NUM_COLS - 1, (r + 1) % NUM_ROWS);
        assign rot_w[r] = rk_i[SRC];
        aes_sbox u_sbox (
            .in_i  (rot_w[r]),
            .out_o (sub_w[r])
        );
        if (r == 0) begin : g_top
            assign mix_w[r] = sub_w[r] ^ step_const_i;
        end else begin : g_rest
            assign mix_w[r] = sub_w[r];
        end
    end

    always_comb begin
        byte_t run;
        rk_o = '0;
        for (int r = 0; r < NUM_ROWS; r++) begin
            run = mix_w[r];
            for (int c = 0; c < NUM_COLS; c++) begin
                run = run ^ rk_i[slot(c, r)];
                rk_o[slot(c, r)] = run;
            end
        end
    end

endmodule

// File: rtl/aes_round.sv
module aes_round
    import aes_core_pkg::*;
(
    input  state_t st_i,
    input  state_t rk_i,
    input  logic   last_i,
    output state_t st_o
);

    state_t sub_s;
    state_t shf_s;
    state_t mix_s;

    for (genvar b = 0; b < BLK_BYTES; b++) begin : g_sub
        aes_sbox u_sbox (
            .in_i  (st_i[b]),
            .out_o (sub_s[b])
        );
    end

    // R6: row r turned left by r byte positions
    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
        for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
            localparam int DST = slot(c, r);
            localparam int SRC = slot((c + r) % NUM_COLS, r);
            localparam int M1  = slot(c, (r + 1) % NUM_ROWS);
            localparam int M2  = slot(c, (r + 2) % NUM_ROWS);
            localparam int M3  = slot(c, (r + 3) % NUM_ROWS);
            assign shf_s[DST] = sub_s[SRC];
            // R7: column times 03x^3+01x^2+01x+02
            assign mix_s[DST] = mix_byte(shf_s[DST], shf_s[M1], shf_s[M2], shf_s[M3]);
        end
    end

    assign st_o = (last_i ? shf_s : mix_s) ^ rk_i;

endmodule

// File: rtl/aes128_iter_core.sv
module aes128_iter_core
    import aes_core_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [BLK_W-1:0] key_i,
    input  logic [BLK_W-1:0] ptext_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [BLK_W-1:0] ctext_o
);

    ctl_e              ctl_q;
    logic [RND_W-1:0]  round_q;
    byte_t             step_q;
    state_t            st_q;
    state_t            rk_q;
    state_t            rk_next;
    state_t            st_next;
    logic              last_round;
    logic              accept;

    assign last_round = (round_q == RND_W'(NUM_ROUNDS));
    assign accept     = start_i && (ctl_q != CTL_RUN);

    aes_key_step u_key_step (
        .rk_i         (rk_q),
        .step_const_i (step_q),
        .rk_o         (rk_next)
    );

    aes_round u_round (
        .st_i   (st_q),
        .rk_i   (rk_next),
        .last_i (last_round),
        .st_o   (st_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= CTL_IDLE;
            round_q <= '0;
            step_q  <= STEP_SEED;
            st_q    <= '0;
            rk_q    <= '0;
        end else if (accept) begin
            ctl_q   <= CTL_RUN;
            round_q <= RND_W'(1);
            step_q  <= STEP_SEED;
            st_q    <= state_t'(ptext_i ^ key_i);
            rk_q    <= state_t'(key_i);
        end else if (ctl_q == CTL_RUN) begin
            st_q    <= st_next;
            rk_q    <= rk_next;
            step_q  <= xtime(step_q);
            round_q <= round_q + RND_W'(1);
            if (last_round) ctl_q <= CTL_DONE;
        end
    end

    assign busy_o  = (ctl_q == CTL_RUN);
    assign done_o  = (ctl_q == CTL_DONE);
    assign ctext_o = st_q;

    // checker-only cycle count since the accepted start
    logic [RND_W-1:0] lat_q;
    always_ff @(posedge clk) begin
        if (rst)          lat_q <= '0;
        else if (accept)  lat_q <= '0;
        else if (busy_o)  lat_q <= lat_q + RND_W'(1);
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> !busy_o && !done_o);

    p_start_accept_r2: assert property (@(posedge clk) disable iff (rst)
        start_i && !busy_o |=> busy_o && !done_o);

    p_done_latency_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> lat_q == RND_W'(NUM_ROUNDS) && $fell(busy_o));

    p_step_const_r8: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> step_q inside {8'h01, 8'h02, 8'h04, 8'h08, 8'h10,
                                  8'h20, 8'h40, 8'h80, 8'h1B, 8'h36});

    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (rst)
        busy_o && start_i && !last_round |=> busy_o);

    p_done_hold_r10: assert property (@(posedge clk) disable iff (rst)
        done_o && !start_i |=> done_o && $stable(ctext_o));

endmodule

// File: tb/test_aes128_iter_core.sv
module test_aes128_iter_core;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic [127:0] key_i = '0;
    logic [127:0] ptext_i = '0;
    logic         busy_o;
    logic         done_o;
    logic [127:0] ctext_o;

    always #2 clk = ~clk;   // 250 MHz

    aes128_iter_core i_aes128_iter_core (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .key_i   (key_i),
        .ptext_i (ptext_i),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .ctext_o (ctext_o)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit finished = 1'b0;

    logic [127:0] exp_q[$];
    int           edge_q[$];
    logic [7:0]   sb_tab [256];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 8'h00;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            logic hi;
            if (b[i]) p = p ^ x;
            hi = x[7];
            x = {x[6:0], 1'b0};
            if (hi) x = x ^ 8'h1B;
        end
        return p;
    endfunction

    function automatic logic [7:0] ref_sbox_calc(input logic [7:0] x);
        logic [7:0] inv = 8'h00;
        logic [7:0] o;
        logic [7:0] c = 8'h63;
        for (int y = 1; y < 256; y++)
            if (ref_mul(x, 8'(y)) == 8'h01) inv = 8'(y);
        for (int i = 0; i < 8; i++)
            o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ c[i];
        return o;
    endfunction

    function automatic logic [127:0] ref_encrypt(input logic [127:0] key, input logic [127:0] pt);
        logic [31:0]  w [44];
        logic [7:0]   s [16];
        logic [7:0]   t [16];
        logic [7:0]   rc = 8'h01;
        logic [127:0] res;
        for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            logic [31:0] tmp = w[i-1];
            if (i % 4 == 0) begin
                tmp = {tmp[23:0], tmp[31:24]};
                tmp = {sb_tab[tmp[31:24]], sb_tab[tmp[23:16]], sb_tab[tmp[15:8]], sb_tab[tmp[7:0]]};
                tmp[31:24] = tmp[31:24] ^ rc;
                rc = ref_mul(rc, 8'h02);
            end
            w[i] = w[i-4] ^ tmp;
        end
        for (int k = 0; k < 16; k++)
            s[k] = pt[127-8*k -: 8] ^ w[k/4][31-8*(k%4) -: 8];
        for (int rnd = 1; rnd <= 10; rnd++) begin
            for (int k = 0; k < 16; k++) s[k] = sb_tab[s[k]];
            for (int c = 0; c < 4; c++)
                for (int r = 0; r < 4; r++) t[c*4+r] = s[((c+r)%4)*4+r];
            for (int c = 0; c < 4; c++) begin
                if (rnd < 10) begin
                    s[c*4+0] = ref_mul(t[c*4],8'h02)^ref_mul(t[c*4+1],8'h03)^t[c*4+2]^t[c*4+3];
                    s[c*4+1] = t[c*4]^ref_mul(t[c*4+1],8'h02)^ref_mul(t[c*4+2],8'h03)^t[c*4+3];
                    s[c*4+2] = t[c*4]^t[c*4+1]^ref_mul(t[c*4+2],8'h02)^ref_mul(t[c*4+3],8'h03);
                    s[c*4+3] = ref_mul(t[c*4],8'h03)^t[c*4+1]^t[c*4+2]^ref_mul(t[c*4+3],8'h02);
                end else begin
                    for (int r = 0; r < 4; r++) s[c*4+r] = t[c*4+r];
                end
                for (int r = 0; r < 4; r++)
                    s[c*4+r] = s[c*4+r] ^ w[4*rnd+c][31-8*r -: 8];
            end
        end
        for (int k = 0; k < 16; k++) res[127-8*k -: 8] = s[k];
        return res;
    endfunction

    // ---------------- driver ----------------
    task automatic send(input logic [127:0] key, input logic [127:0] pt,
                        input logic [127:0] exp, input string req);
        @(negedge clk);
        key_i   = key;
        ptext_i = pt;
        start_i = 1'b1;
        exp_q.push_back(exp);
        edge_q.push_back(cyc + 1);
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o && !done_o, {req, " busy after start (R2)"},
              {126'd0, busy_o, done_o}, 128'd2);
    endtask

    task automatic wait_done();
        while (!done_o) @(negedge clk);
    endtask

    // ---------------- monitor ----------------
    logic prev_done = 1'b0;
    always @(negedge clk) begin
        if (!rst && done_o && !prev_done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected done", ctext_o, '0);
            end else begin
                logic [127:0] e;
                int           ed;
                e  = exp_q.pop_front();
                ed = edge_q.pop_front();
                check(ctext_o == e, "R4/R5/R6/R7/R8 ciphertext", ctext_o, e);
                check(cyc - ed == 10 && !busy_o, "R3 latency", 128'(cyc - ed), 128'd10);
            end
        end
        prev_done <= done_o;
    end

    // ---------------- watchdog ----------------
    always @(negedge clk) begin
        if (cyc > 20000 && !finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<20000", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // ---------------- sequence ----------------
    initial begin
        logic [127:0] k, p, e, held;
        for (int i = 0; i < 256; i++) sb_tab[i] = ref_sbox_calc(8'(i));

        repeat (3) @(negedge clk);
        check(!busy_o && !done_o, "R1 in reset", {126'd0, busy_o, done_o}, '0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy_o && !done_o, "R1 after reset", {126'd0, busy_o, done_o}, '0);

        // fixed answer vectors
        send(128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff,
             128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R4 vec1");
        wait_done();
        send(128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3243f6a8885a308d313198a2e0370734,
             128'h3925841d02dc09fbdc118597196a0b32, "R4 vec2");
        wait_done();
        send(128'h0, 128'h0, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e, "R5 zero");
        wait_done();
        send({16{8'hff}}, {16{8'hff}}, ref_encrypt({16{8'hff}}, {16{8'hff}}), "R5 ones");
        wait_done();

        // random blocks against the model
        for (int n = 0; n < 6; n++) begin
            k = {$urandom, $urandom, $urandom, $urandom};
            p = {$urandom, $urandom, $urandom, $urandom};
            send(k, p, ref_encrypt(k, p), "R6/R7 random");
            wait_done();
        end

        // R9: second start in mid-run is ignored
        k = {$urandom, $urandom, $urandom, $urandom};
        p = {$urandom, $urandom, $urandom, $urandom};
        send(k, p, ref_encrypt(k, p), "R9 first");
        repeat (3) @(negedge clk);
        key_i   = ~k;
        ptext_i = ~p;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o && !done_o, "R9 still busy", {126'd0, busy_o, done_o}, 128'd2);
        wait_done();

        // R10: done and ciphertext hold
        held = ctext_o;
        for (int n = 0; n < 5; n++) begin
            @(negedge clk);
            check(done_o && ctext_o == held, "R10 hold", ctext_o, held);
        end

        // R10/R2: restart from done clears done at once
        k = {$urandom, $urandom, $urandom, $urandom};
        p = {$urandom, $urandom, $urandom, $urandom};
        e = ref_encrypt(k, p);
        send(k, p, e, "R10 restart");
        wait_done();
        @(negedge clk);

        check(exp_q.size() == 0, "R4 all results seen", 128'(exp_q.size()), '0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule